// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block chooses which interrupt should be serviced next. Each of its request lines comes with an 8-bit priority value. Only the top `IMPL_BITS` bits of that value are kept. Among the lines that are requesting and not blocked, the line with the numerically smallest priority wins. Two fixed sources sit above every line: a non-maskable input and a hard-fault input. Three gates can hold requests back. The disable-all gate blocks every line. The fault gate also blocks the hard-fault input. The threshold gate blocks lines whose priority is at or below a given level.

Once a winner is chosen, the block decides whether that winner may interrupt the handler that is running now. The group selector splits each priority value into two parts. The upper part is the preempt level and the lower part is the sub-priority. Preemption needs a strictly better preempt level. The sub-priority only decides the order between requests that are pending together. All results are registered, so they appear one clock after their inputs.

Top module: `prio_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take these values on that edge: `win_src`=0 (none), `win_id`=0, `win_prio`=0, `preempt_req`=0.
- R2: Among the eligible lines, the one with the smallest trimmed priority is reported with `win_src`=1, `win_id` and `win_prio`, one clock after the inputs are presented.
- R3: When eligible lines have equal trimmed priority, the lowest line index wins.
- R4: Priority bits below the top `IMPL_BITS` bits are ignored and reported as zero. With 3 bits, the values 0x3F and 0x20 rank equal.
- R5: `group_sel`=g makes bits 7 down to g+1 the preempt level (g=7 leaves no preempt bits). A winning line raises `preempt_req` when `run_kind`=0 (thread). When `run_kind`=1 (programmable handler at `run_prio`), it raises `preempt_req` only if its preempt level is strictly smaller than the preempt level of the trimmed `run_prio`.
- R6: Among lines with the same preempt level, the smaller sub-priority is selected. A better sub-priority alone never raises `preempt_req`.
- R7: `mask_all`=1 blocks every line. It does not block the fault or non-maskable inputs.
- R8: `mask_fault`=1 blocks every line and also the fault input. It does not block the non-maskable input.
- R9: A threshold that is nonzero after trimming blocks lines whose trimmed priority is greater than or equal to it. A zero threshold blocks nothing.
- R10: `nmi_req` wins over everything (`win_src`=3). It raises `preempt_req` unless `run_kind`=3 (non-maskable running).
- R11: An unblocked `fault_req` wins over any line (`win_src`=2). It raises `preempt_req` only for `run_kind` 0 or 1.
- R12: While `run_kind` is 2 (fault) or 3 (non-maskable), a winning line is still reported but never raises `preempt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_req | input | N_LINES | Pending-and-enabled request per line |
| line_prio | input | 8*N_LINES | Priority of line i in bits [8i+7:8i] |
| nmi_req | input | 1 | Non-maskable request |
| fault_req | input | 1 | Hard-fault request |
| mask_all | input | 1 | Blocks all lines |
| mask_fault | input | 1 | Blocks all lines and the fault input |
| threshold | input | 8 | Priority threshold, 0 means off |
| group_sel | input | 3 | Split point between preempt level and sub-priority |
| run_kind | input | 2 | Running context: 0 thread, 1 programmable, 2 fault, 3 non-maskable |
| run_prio | input | 8 | Priority of the running programmable handler |
| win_src | output | 2 | Winner kind: 0 none, 1 line, 2 fault, 3 non-maskable |
| win_id | output | $clog2(N_LINES) | Winning line index (0 unless `win_src`=1) |
| win_prio | output | 8 | Trimmed priority of the winning line (0 unless `win_src`=1) |
| preempt_req | output | 1 | The winner may interrupt the running context |

## Verification
Assertions check on every cycle that:
- the non-maskable input always wins and preempts;
- the two mask gates empty the line winner;
- a reported line sits strictly above an active threshold and has no unimplemented bits;
- the picked index is actually eligible;
- a line never preempts a fixed-level handler.

Some behaviour can only be shown by the directed scenarios, because it depends on the relative priority values. This covers:
- lowest-value selection and index tie-breaking;
- trimming making two different raw values rank equal;
- the preempt boundary moving with the group setting;
- a sub-priority win that does not preempt.

// File: rtl/prio_pkg.sv
// Package: shared encodings and helpers for the priority resolver.
// Assumes priority fields are 8 bits with the implemented bits at the top.
package prio_pkg;
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LINE  = 2'd1,
        SRC_FAULT = 2'd2,
        SRC_NMI   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        RUN_THREAD = 2'd0,
        RUN_PROG   = 2'd1,
        RUN_FAULT  = 2'd2,
        RUN_NMI    = 2'd3
    } run_e;

    // Mask keeping the top impl bits of an 8-bit priority.
    function automatic logic [7:0] keep_mask(int impl);
        return 8'hFF << (8 - impl);
    endfunction
endpackage

// File: rtl/prio_qualify.sv
// prio_qualify: trims each line priority to the implemented bits and decides
// which lines are eligible after the disable-all, fault and threshold gates.
// Assumes threshold arrives untrimmed; it is trimmed here the same way.
module prio_qualify #(
    parameter int N_LINES   = 8,
    parameter int IMPL_BITS = 3
) (
    input  logic [N_LINES-1:0]      req,
    input  logic [N_LINES*8-1:0]    prio_raw,
    input  logic                    mask_all,
    input  logic                    mask_fault,
    input  logic [7:0]              threshold,
    output logic [N_LINES-1:0][7:0] prio_trim,
    output logic [N_LINES-1:0]      eligible
);
    import prio_pkg::*;

    localparam logic [7:0] KEEP = keep_mask(IMPL_BITS);

    logic [7:0] thr_trim;
    logic       thr_on;
    logic       gate_off;

    // Trimmed threshold and the global gate shared by all lines.
    always_comb begin
        thr_trim = threshold & KEEP;
        thr_on   = (thr_trim != 8'd0);
        gate_off = mask_all | mask_fault;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        // Per-line trim and eligibility.
        always_comb begin
            prio_trim[i] = prio_raw[i*8 +: 8] & KEEP;
            eligible[i]  = req[i] && !gate_off && !(thr_on && (prio_trim[i] >= thr_trim));
        end
    end
endmodule

// File: rtl/prio_pick.sv
// prio_pick: finds the eligible line with the smallest priority, lowest
// index first on ties. Assumes priorities are already trimmed.
module prio_pick #(
    parameter int N_LINES = 8,
    localparam int IDW    = $clog2(N_LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_LINES-1:0]      eligible,
    input  logic [N_LINES-1:0][7:0] prio,
    output logic                    any,
    output logic [IDW-1:0]          idx,
    output logic [7:0]              best
);
    // Linear scan; strict compare keeps the lowest index on equal priority.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = 8'hFF;
        for (int i = 0; i < N_LINES; i++) begin
            if (eligible[i] && (!any || prio[i] < best)) begin
                any  = 1'b1;
                idx  = IDW'(i);
                best = prio[i];
            end
        end
    end

    // R2: the reported index must be an eligible line carrying the reported priority.
    p_pick_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (eligible[idx] && prio[idx] == best));
endmodule

// File: rtl/prio_preempt.sv
// prio_preempt: ranks the fixed sources above the line winner and decides
// whether the chosen winner may interrupt the running context.
// Assumes line and running priorities are already trimmed.
module prio_preempt (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_req,
    input  logic                 fault_ok,
    input  logic                 line_any,
    input  logic [7:0]           line_prio,
    input  logic [2:0]           group_sel,
    input  prio_pkg::run_e       run_kind,
    input  logic [7:0]           run_prio,
    output prio_pkg::src_e       src,
    output logic                 preempt
);
    import prio_pkg::*;

    logic [7:0] pmask;
    logic       line_better;

    // Preempt field is bits 7..g+1; a shift by 8 leaves no preempt bits.
    always_comb begin
        pmask       = 8'hFF << (int'(group_sel) + 1);
        line_better = (line_prio & pmask) < (run_prio & pmask);
    end

    // Source ranking and preemption decision.
    always_comb begin
        src     = SRC_NONE;
        preempt = 1'b0;
        if (nmi_req) begin
            src     = SRC_NMI;
            preempt = (run_kind != RUN_NMI);
        end else if (fault_ok) begin
            src     = SRC_FAULT;
            preempt = (run_kind == RUN_THREAD) || (run_kind == RUN_PROG);
        end else if (line_any) begin
            src     = SRC_LINE;
            preempt = (run_kind == RUN_THREAD) || ((run_kind == RUN_PROG) && line_better);
        end
    end

    // R12: a line never interrupts a fixed-level handler.
    p_no_line_over_fixed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_LINE && (run_kind == RUN_FAULT || run_kind == RUN_NMI)) |-> !preempt);
endmodule

// File: rtl/prio_resolver.sv
// prio_resolver: top level. Qualifies and trims line priorities, picks the
// best line, ranks fixed sources above it, and registers the result
// (one clock of latency). Assumes 3 <= IMPL_BITS <= 8 and N_LINES >= 2.
module prio_resolver #(
    parameter int N_LINES   = 8,
    parameter int IMPL_BITS = 3,
    localparam int IDW      = $clog2(N_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LINES-1:0]   line_req,
    input  logic [N_LINES*8-1:0] line_prio,
    input  logic                 nmi_req,
    input  logic                 fault_req,
    input  logic                 mask_all,
    input  logic                 mask_fault,
    input  logic [7:0]           threshold,
    input  logic [2:0]           group_sel,
    input  logic [1:0]           run_kind,
    input  logic [7:0]           run_prio,
    output logic [1:0]           win_src,
    output logic [IDW-1:0]       win_id,
    output logic [7:0]           win_prio,
    output logic                 preempt_req
);
    import prio_pkg::*;

    localparam logic [7:0] KEEP = keep_mask(IMPL_BITS);

    logic [N_LINES-1:0][7:0] prio_trim;
    logic [N_LINES-1:0]      eligible;
    logic                    line_any;
    logic [IDW-1:0]          line_idx;
    logic [7:0]              line_best;
    src_e                    src_c;
    logic                    preempt_c;
    logic                    fault_ok;
    logic [7:0]              run_trim;

    // Fault input is gated only by the fault mask; running priority is trimmed.
    always_comb begin
        fault_ok = fault_req && !mask_fault;
        run_trim = run_prio & KEEP;
    end

    prio_qualify #(.N_LINES(N_LINES), .IMPL_BITS(IMPL_BITS)) u_qualify (
        .req(line_req), .prio_raw(line_prio), .mask_all(mask_all),
        .mask_fault(mask_fault), .threshold(threshold),
        .prio_trim(prio_trim), .eligible(eligible)
    );

    prio_pick #(.N_LINES(N_LINES)) u_pick (
        .clk(clk), .rst_n(rst_n), .eligible(eligible), .prio(prio_trim),
        .any(line_any), .idx(line_idx), .best(line_best)
    );

    prio_preempt u_preempt (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .fault_ok(fault_ok),
        .line_any(line_any), .line_prio(line_best), .group_sel(group_sel),
        .run_kind(run_e'(run_kind)), .run_prio(run_trim),
        .src(src_c), .preempt(preempt_c)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_src     <= SRC_NONE;
            win_id      <= '0;
            win_prio    <= 8'd0;
            preempt_req <= 1'b0;
        end else begin
            win_src     <= src_c;
            win_id      <= (src_c == SRC_LINE) ? line_idx : '0;
            win_prio    <= (src_c == SRC_LINE) ? line_best : 8'd0;
            preempt_req <= preempt_c;
        end
    end

    // R10: non-maskable request is reported next cycle.
    p_nmi_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> (win_src == SRC_NMI));
    // R10: it preempts anything but a running non-maskable handler.
    p_nmi_preempts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && run_kind != RUN_NMI) |=> preempt_req);
    // R7: disable-all leaves no winner unless a fixed source asks.
    p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all && !nmi_req && !fault_req) |=> (win_src == SRC_NONE));
    // R8: fault mask leaves no winner unless the non-maskable input asks.
    p_mask_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_fault && !nmi_req) |=> (win_src == SRC_NONE));
    // R9: a reported line lies strictly above an active threshold.
    p_threshold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_src == SRC_LINE && ($past(threshold) & KEEP) != 8'd0)
        |-> (win_prio < ($past(threshold) & KEEP)));
    // R4: unimplemented bits of the reported priority read as zero.
    p_trimmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_prio & ~KEEP) == 8'd0);
endmodule

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
    localparam int N = 8;
    localparam int IDW = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     line_req;
    logic [N*8-1:0]   line_prio;
    logic             nmi_req, fault_req, mask_all, mask_fault;
    logic [7:0]       threshold, run_prio;
    logic [2:0]       group_sel;
    logic [1:0]       run_kind;
    logic [1:0]       win_src;
    logic [IDW-1:0]   win_id;
    logic [7:0]       win_prio;
    logic             preempt_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prio_resolver #(.N_LINES(N), .IMPL_BITS(3)) i_prio_resolver (
        .clk(clk), .rst_n(rst_n), .line_req(line_req), .line_prio(line_prio),
        .nmi_req(nmi_req), .fault_req(fault_req), .mask_all(mask_all),
        .mask_fault(mask_fault), .threshold(threshold), .group_sel(group_sel),
        .run_kind(run_kind), .run_prio(run_prio), .win_src(win_src),
        .win_id(win_id), .win_prio(win_prio), .preempt_req(preempt_req)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        line_req = '0; line_prio = '0; nmi_req = 0; fault_req = 0;
        mask_all = 0; mask_fault = 0; threshold = 0; group_sel = 0;
        run_kind = 0; run_prio = 0;
    endtask

    task automatic req(int i, int p);
        line_req[i] = 1'b1;
        line_prio[i*8 +: 8] = 8'(p);
    endtask

    // Inputs change after the edge; sample one cycle later, 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_win(string tag, int src, int id, int pr, int pre);
        chk({tag, " src"}, win_src, src);
        chk({tag, " id"}, win_id, id);
        chk({tag, " prio"}, win_prio, pr);
        chk({tag, " preempt"}, preempt_req, pre);
    endtask

    task automatic t_reset();   // R1
        idle(); nmi_req = 1; req(0, 0);
        rst_n = 0;
        step(); step();
        expect_win("R1 reset", 0, 0, 0, 0);
        rst_n = 1; idle();
    endtask

    task automatic t_lowest();  // R2
        idle(); req(2, 8'h80); req(5, 8'h40); req(7, 8'hE0);
        step();
        expect_win("R2 lowest", 1, 5, 8'h40, 1);
    endtask

    task automatic t_tie();     // R3
        idle(); req(6, 8'h60); req(3, 8'h60);
        step();
        expect_win("R3 tie", 1, 3, 8'h60, 1);
    endtask

    task automatic t_trim();    // R4
        idle(); req(0, 8'h3F); req(1, 8'h20);
        step();
        expect_win("R4 trim", 1, 0, 8'h20, 1);
    endtask

    task automatic t_group();   // R5
        idle(); run_kind = 1; run_prio = 8'h60; group_sel = 0; req(4, 8'h40);
        step(); expect_win("R5 g0 better", 1, 4, 8'h40, 1);
        idle(); run_kind = 1; run_prio = 8'h60; group_sel = 0; req(4, 8'h60);
        step(); expect_win("R5 g0 equal", 1, 4, 8'h60, 0);
        idle(); run_kind = 1; run_prio = 8'h40; group_sel = 5; req(1, 8'h20);
        step(); expect_win("R5 g5 better", 1, 1, 8'h20, 1);
        idle(); run_kind = 1; run_prio = 8'h40; group_sel = 5; req(1, 8'h60);
        step(); expect_win("R5 g5 same level", 1, 1, 8'h60, 0);
    endtask

    task automatic t_sub();     // R6
        idle(); run_kind = 1; run_prio = 8'h40; group_sel = 6;
        req(2, 8'h60); req(5, 8'h20);
        step(); expect_win("R6 sub order", 1, 5, 8'h20, 0);
    endtask

    task automatic t_mask_all(); // R7
        idle(); mask_all = 1; req(0, 0); req(3, 8'h20);
        step(); expect_win("R7 lines blocked", 0, 0, 0, 0);
        fault_req = 1;
        step(); expect_win("R7 fault passes", 2, 0, 0, 1);
    endtask

    task automatic t_mask_fault(); // R8
        idle(); mask_fault = 1; fault_req = 1; req(1, 0);
        step(); expect_win("R8 fault blocked", 0, 0, 0, 0);
        nmi_req = 1;
        step(); expect_win("R8 nmi passes", 3, 0, 0, 1);
    endtask

    task automatic t_threshold(); // R9
        idle(); threshold = 8'h40; req(0, 8'h40); req(1, 8'h60); req(2, 8'h20);
        step(); expect_win("R9 above thr", 1, 2, 8'h20, 1);
        idle(); threshold = 8'h5F; req(4, 8'h40);
        step(); expect_win("R9 equal blocked", 0, 0, 0, 0);
        idle(); threshold = 8'h1F; req(6, 8'hE0);
        step(); expect_win("R9 zero after trim", 1, 6, 8'hE0, 1);
    endtask

    task automatic t_nmi();     // R10
        idle(); nmi_req = 1; fault_req = 1; req(0, 0); run_kind = 2;
        step(); expect_win("R10 nmi over fault", 3, 0, 0, 1);
        run_kind = 3;
        step(); expect_win("R10 nmi running", 3, 0, 0, 0);
    endtask

    task automatic t_fault();   // R11
        idle(); fault_req = 1; req(0, 0); run_kind = 1; run_prio = 8'h00;
        step(); expect_win("R11 fault over line", 2, 0, 0, 1);
        run_kind = 2;
        step(); expect_win("R11 fault running", 2, 0, 0, 0);
    endtask

    task automatic t_fixed_run(); // R12
        idle(); run_kind = 2; req(3, 8'h00);
        step(); expect_win("R12 under fault", 1, 3, 0, 0);
        run_kind = 3;
        step(); expect_win("R12 under nmi", 1, 3, 0, 0);
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        #1;
        t_reset();
        t_lowest();
        t_tie();
        t_trim();
        t_group();
        t_sub();
        t_mask_all();
        t_mask_fault();
        t_threshold();
        t_nmi();
        t_fault();
        t_fixed_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule